// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timer

This block turns single-byte requests from a host into timed bus cycles on an 8-bit NAND flash interface. A host issues a command byte, an address byte, a data byte to write, or a request to read one data byte. The block then drives the latch enables, the write or read strobe and the data bus through three programmable phases: a setup phase before the strobe falls, the strobe-low phase, and a hold phase after the strobe rises.

The three phase lengths come from one configuration word. Each field holds the length in clocks minus one, so no phase can ever be zero clocks long. The values are sampled when a request is accepted, so the whole cycle runs on one consistent set of lengths. The host port uses a valid/ready handshake: a request made while a cycle is running waits and is not lost.

The block also holds an active-low chip enable that the host selects or deselects. A low-power input forces the enable high and gives back the held value on wake. The flash ready/busy pin is passed through a synchronizer to a status output.

Top module: `nand_cycle_timer`

## Requirements
- R1: The configuration word holds the setup length minus one in bits [1:0], the strobe length minus one in bits [4:2] and the hold length minus one in bits [7:5]. An accepted request spends exactly setup, then strobe, then hold clocks in those phases (1–4, 1–8 and 1–8 clocks).
- R2: After reset, with no configuration written, the phases last 4, 8 and 8 clocks.
- R3: The request kind uses 0 for command, 1 for address, 2 for data write and 3 for data read. A command drives f_cle=1 and f_ale=0. An address drives f_ale=1 and f_cle=0. Both data kinds drive both low.
- R4: f_cle, f_ale, f_dq_oe and f_dq_out hold their values from the first setup clock to the last hold clock. f_we_n is low only during the strobe phase of the kinds 0 to 2. f_dq_oe is high for the kinds 0 to 2.
- R5: req_ready is high only when no cycle is running. A request is taken at a clock edge where req_valid and req_ready are both high. A request held during a running cycle starts once that cycle ends, with its own byte and kind.
- R6: A read request (kind 3) drives f_re_n low only during its strobe phase and keeps f_dq_oe low. It captures f_dq_in from the last strobe clock into rd_data, and rd_valid is high for the one clock after (the first hold clock).
- R7: f_ce_n is high after reset. A clock with sel_wr=1 sets f_ce_n to the inverse of sel_on from the next clock on.
- R8: While sleep is high, f_ce_n is high in the same clock. When sleep falls, the held selection shows again, including any selection written during sleep.
- R9: dev_ready (1 = ready, 0 = busy) follows rb_in two clock edges later and is 1 after reset.
- R10: A configuration write made while a cycle is running does not change that cycle. The next accepted request uses the new lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load cfg_word into the timing register |
| cfg_word | input | 8 | Phase lengths minus one: hold, strobe, setup |
| req_valid | input | 1 | Host request present |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | 8 | Byte to issue |
| req_ready | output | 1 | Block idle, request can be taken |
| rd_data | output | 8 | Byte captured by a read cycle |
| rd_valid | output | 1 | One-clock pulse when rd_data is new |
| sel_wr | input | 1 | Update the chip selection |
| sel_on | input | 1 | 1 selects the device, 0 deselects |
| sleep | input | 1 | Low-power hold, forces chip enable off |
| rb_in | input | 1 | Flash ready/busy pin |
| dev_ready | output | 1 | Synchronized ready level |
| f_cle | output | 1 | Command latch enable |
| f_ale | output | 1 | Address latch enable |
| f_we_n | output | 1 | Write strobe, active low |
| f_re_n | output | 1 | Read strobe, active low |
| f_ce_n | output | 1 | Chip enable, active low |
| f_dq_out | output | 8 | Data bus output value |
| f_dq_oe | output | 1 | Data bus output enable |
| f_dq_in | input | 8 | Data bus input value |

## Verification
A request taken at edge k shows its setup phase in the clock after that edge. The strobe starts setup clocks later and the hold starts strobe clocks after that. req_ready returns after setup+strobe+hold clocks, and rd_valid rises with the first hold clock. The bench samples at every falling edge of the window and compares with the phase index it works out from the three lengths. It sweeps all 256 length combinations and rotates through the four kinds. Chip-enable updates are checked one edge after sel_wr, sleep effects in the same clock, and dev_ready exactly after the second edge.

// File: rtl/nct_pkg.sv
package nct_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_WR   = 2'd2,
        K_RD   = 2'd3
    } kind_e;

endpackage

// File: rtl/nct_sync.sv
module nct_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_d, stage_q;

    assign stage_d[0] = d;
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        assign stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= stage_d;
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/nct_cfg.sv
module nct_cfg #(
    parameter int SETUP_W = 2,
    parameter int PHASE_W = 3,
    localparam int CFG_W  = SETUP_W + 2 * PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic               sel_wr,
    input  logic               sel_on,
    input  logic               sleep,
    output logic [SETUP_W-1:0] len_setup,
    output logic [PHASE_W-1:0] len_strobe,
    output logic [PHASE_W-1:0] len_hold,
    output logic               ce_n
);
    typedef struct packed {
        logic [CFG_W-1:0] word;
        logic             ce_n;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) st_d.word = cfg_word;
        if (sel_wr) st_d.ce_n = ~sel_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= '1;
            st_q.ce_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_setup  = st_q.word[SETUP_W-1:0];
    assign len_strobe = st_q.word[SETUP_W +: PHASE_W];
    assign len_hold   = st_q.word[SETUP_W+PHASE_W +: PHASE_W];
    assign ce_n       = st_q.ce_n | sleep;
endmodule

// File: rtl/nct_engine.sv
module nct_engine
    import nct_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 2,
    parameter int PHASE_W = 3,
    localparam int CNT_W  = (PHASE_W > SETUP_W) ? PHASE_W : SETUP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SETUP_W-1:0] len_setup,
    input  logic [PHASE_W-1:0] len_strobe,
    input  logic [PHASE_W-1:0] len_hold,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [DATA_W-1:0]  req_byte,
    output logic               req_ready,
    input  logic [DATA_W-1:0]  f_dq_in,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               f_cle,
    output logic               f_ale,
    output logic               f_we_n,
    output logic               f_re_n,
    output logic [DATA_W-1:0]  f_dq_out,
    output logic               f_dq_oe
);
    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        kind_e              kind;
        logic [DATA_W-1:0]  dat;
        logic [PHASE_W-1:0] strobe;
        logic [PHASE_W-1:0] hold;
        logic [DATA_W-1:0]  rdat;
        logic               rvld;
    } eng_t;

    eng_t st_d, st_q;
    logic last;

    assign last = (st_q.cnt == '0);

    always_comb begin
        st_d      = st_q;
        st_d.rvld = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase  = PH_SETUP;
                    st_d.cnt    = CNT_W'(len_setup);
                    st_d.kind   = kind_e'(req_kind);
                    st_d.dat    = req_byte;
                    st_d.strobe = len_strobe;
                    st_d.hold   = len_hold;
                end
            end
            PH_SETUP: begin
                if (last) begin
                    st_d.phase = PH_STROBE;
                    st_d.cnt   = CNT_W'(st_q.strobe);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (last) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = CNT_W'(st_q.hold);
                    if (st_q.kind == K_RD) begin
                        st_d.rdat = f_dq_in;
                        st_d.rvld = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (last) st_d.phase = PH_IDLE;
                else      st_d.cnt   = st_q.cnt - 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.cnt    <= '0;
            st_q.kind   <= K_CMD;
            st_q.dat    <= '0;
            st_q.strobe <= '0;
            st_q.hold   <= '0;
            st_q.rdat   <= '0;
            st_q.rvld   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    logic active, in_strobe, is_rd;
    assign active    = (st_q.phase != PH_IDLE);
    assign in_strobe = (st_q.phase == PH_STROBE);
    assign is_rd     = (st_q.kind == K_RD);

    assign req_ready = ~active;
    assign f_cle     = active & (st_q.kind == K_CMD);
    assign f_ale     = active & (st_q.kind == K_ADDR);
    assign f_dq_oe   = active & ~is_rd;
    assign f_dq_out  = f_dq_oe ? st_q.dat : '0;
    assign f_we_n    = ~(in_strobe & ~is_rd);
    assign f_re_n    = ~(in_strobe & is_rd);
    assign rd_data   = st_q.rdat;
    assign rd_valid  = st_q.rvld;
endmodule

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer #(
    parameter int DATA_W      = 8,
    parameter int SETUP_W     = 2,
    parameter int PHASE_W     = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CFG_W      = SETUP_W + 2 * PHASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_byte,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              sel_wr,
    input  logic              sel_on,
    input  logic              sleep,
    input  logic              rb_in,
    output logic              dev_ready,
    output logic              f_cle,
    output logic              f_ale,
    output logic              f_we_n,
    output logic              f_re_n,
    output logic              f_ce_n,
    output logic [DATA_W-1:0] f_dq_out,
    output logic              f_dq_oe,
    input  logic [DATA_W-1:0] f_dq_in
);
    logic [SETUP_W-1:0] len_setup;
    logic [PHASE_W-1:0] len_strobe, len_hold;

    nct_cfg #(.SETUP_W(SETUP_W), .PHASE_W(PHASE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .sel_wr(sel_wr), .sel_on(sel_on), .sleep(sleep),
        .len_setup(len_setup), .len_strobe(len_strobe), .len_hold(len_hold),
        .ce_n(f_ce_n)
    );

    nct_engine #(.DATA_W(DATA_W), .SETUP_W(SETUP_W), .PHASE_W(PHASE_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .len_setup(len_setup), .len_strobe(len_strobe), .len_hold(len_hold),
        .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
        .req_ready(req_ready), .f_dq_in(f_dq_in),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .f_cle(f_cle), .f_ale(f_ale), .f_we_n(f_we_n), .f_re_n(f_re_n),
        .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe)
    );

    nct_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rb_sync (
        .clk(clk), .rst_n(rst_n), .d(rb_in), .q(dev_ready)
    );
endmodule

// File: rtl/nct_checks.sv
module nct_checks #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              sel_wr,
    input logic              sel_on,
    input logic              sleep,
    input logic              rb_in,
    input logic              dev_ready,
    input logic              f_cle,
    input logic              f_ale,
    input logic              f_we_n,
    input logic              f_re_n,
    input logic              f_ce_n,
    input logic [DATA_W-1:0] f_dq_out,
    input logic              f_dq_oe
);
    p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_cle && f_ale));

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!f_we_n && !f_re_n));

    p_we_needs_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !f_we_n |-> f_dq_oe);

    p_busy_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_bus_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |->
            ($stable(f_dq_out) && $stable(f_cle) && $stable(f_ale) && $stable(f_dq_oe)));

    p_ce_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sleep || (f_ce_n == !$past(sel_on))));

    p_sleep_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> f_ce_n);

    p_sync_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_ready) |-> (dev_ready == $past(rb_in, 2)));
endmodule

bind nand_cycle_timer nct_checks #(.DATA_W(DATA_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .sel_wr(sel_wr), .sel_on(sel_on), .sleep(sleep), .rb_in(rb_in),
    .dev_ready(dev_ready), .f_cle(f_cle), .f_ale(f_ale), .f_we_n(f_we_n),
    .f_re_n(f_re_n), .f_ce_n(f_ce_n), .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe)
);

// File: tb/nand_cycle_timer_test.sv
module nand_cycle_timer_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_word = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [7:0] req_byte = '0;
    logic       req_ready;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       sel_wr = 1'b0, sel_on = 1'b0, sleep = 1'b0, rb_in = 1'b1;
    logic       dev_ready;
    logic       f_cle, f_ale, f_we_n, f_re_n, f_ce_n, f_dq_oe;
    logic [7:0] f_dq_out;
    logic [7:0] f_dq_in = '0;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    nand_cycle_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .sel_wr(sel_wr), .sel_on(sel_on), .sleep(sleep), .rb_in(rb_in),
        .dev_ready(dev_ready), .f_cle(f_cle), .f_ale(f_ale), .f_we_n(f_we_n),
        .f_re_n(f_re_n), .f_ce_n(f_ce_n), .f_dq_out(f_dq_out),
        .f_dq_oe(f_dq_oe), .f_dq_in(f_dq_in)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mk_cfg(input int s, input int p, input int h);
        return 8'(((h - 1) << 5) | ((p - 1) << 2) | (s - 1));
    endfunction

    task automatic write_cfg(input logic [7:0] w);
        @(negedge clk); cfg_wr = 1'b1; cfg_word = w;
        @(posedge clk); @(negedge clk); cfg_wr = 1'b0;
    endtask

    // One request; every clock of its window is compared with the phase index.
    task automatic run_req(input logic [1:0] k, input logic [7:0] b,
                           input int s, input int p, input int h, input string tag,
                           input bit stall, input bit mid, input logic [7:0] mid_w);
        int n;
        logic [4:0] exp_v, act_v;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_byte = b; f_dq_in = ~b;
        check(req_ready == 1'b1, {tag, " R5 idle ready"}, 32'(req_ready), 32'd1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        n = s + p + h;
        for (int i = 0; i < n; i++) begin
            bit strobe;
            if (mid && i == 0) begin cfg_wr = 1'b1; cfg_word = mid_w; end
            if (mid && i == 1) cfg_wr = 1'b0;
            if (stall && i == 1) begin req_valid = 1'b1; req_kind = 2'd1; req_byte = ~b; end
            strobe = (i >= s) && (i < s + p);
            exp_v = {k == 2'd0, k == 2'd1, !(strobe && k != 2'd3), !(strobe && k == 2'd3), k != 2'd3};
            act_v = {f_cle, f_ale, f_we_n, f_re_n, f_dq_oe};
            check(act_v == exp_v, {tag, " R1 R3 R4 R6 phase signals"}, 32'(act_v), 32'(exp_v));
            if (k != 2'd3)
                check(f_dq_out == b, {tag, " R4 bus byte"}, 32'(f_dq_out), 32'(b));
            if (i == s + p && k == 2'd3)
                check(rd_valid && rd_data == ~b, {tag, " R6 read capture"},
                      {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, ~b});
            else
                check(!rd_valid, {tag, " R6 no stray rd_valid"}, 32'(rd_valid), 32'd0);
            @(posedge clk); @(negedge clk);
        end
        act_v = {f_cle, f_ale, f_we_n, f_re_n, f_dq_oe};
        check(req_ready && act_v == 5'b00110, {tag, " R1 R5 end of window"},
              {26'd0, req_ready, act_v}, {26'd0, 1'b1, 5'b00110});
        if (stall) begin
            @(posedge clk); @(negedge clk);
            req_valid = 1'b0;
            check(f_ale && !f_cle && f_dq_out == ~b, {tag, " R5 held request started"},
                  {22'd0, f_ale, f_cle, f_dq_out}, {22'd0, 2'b10, ~b});
            for (int j = 0; j < 40 && !req_ready; j++) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({req_ready, f_cle, f_ale, f_we_n, f_re_n, f_ce_n, f_dq_oe, rd_valid} == 8'b10011100,
              "R7 reset outputs", {req_ready, f_cle, f_ale, f_we_n, f_re_n, f_ce_n, f_dq_oe, rd_valid},
              8'b10011100);
        check(dev_ready == 1'b1, "R9 reset status", 32'(dev_ready), 32'd1);

        // R2: default lengths
        run_req(2'd0, 8'hA5, 4, 8, 8, "R2 default", 0, 0, 8'h00);

        // Full sweep of lengths, rotating kinds
        for (int s = 1; s <= 4; s++)
            for (int p = 1; p <= 8; p++)
                for (int h = 1; h <= 8; h++) begin
                    int idx = (s - 1) * 64 + (p - 1) * 8 + (h - 1);
                    write_cfg(mk_cfg(s, p, h));
                    run_req(2'(idx % 4), 8'(idx * 37 + 5), s, p, h, "sweep", 0, 0, 8'h00);
                end

        // R5: request held during a running cycle
        write_cfg(mk_cfg(2, 3, 2));
        run_req(2'd2, 8'h3C, 2, 3, 2, "R5 stall", 1, 0, 8'h00);

        // R10: configuration written mid-cycle
        write_cfg(mk_cfg(2, 3, 2));
        run_req(2'd0, 8'h81, 2, 3, 2, "R10 mid write", 0, 1, mk_cfg(1, 1, 1));
        run_req(2'd3, 8'h42, 1, 1, 1, "R10 new lengths", 0, 0, 8'h00);

        // R7 / R8: chip enable and sleep
        @(negedge clk); sel_wr = 1'b1; sel_on = 1'b1;
        @(posedge clk); @(negedge clk); sel_wr = 1'b0;
        check(f_ce_n == 1'b0, "R7 select", 32'(f_ce_n), 32'd0);
        sleep = 1'b1; #1;
        check(f_ce_n == 1'b1, "R8 sleep forces high", 32'(f_ce_n), 32'd1);
        @(posedge clk); @(negedge clk);
        check(f_ce_n == 1'b1, "R8 sleep held", 32'(f_ce_n), 32'd1);
        sleep = 1'b0; #1;
        check(f_ce_n == 1'b0, "R8 wake restores select", 32'(f_ce_n), 32'd0);
        @(negedge clk); sleep = 1'b1; sel_wr = 1'b1; sel_on = 1'b0;
        @(posedge clk); @(negedge clk); sel_wr = 1'b0;
        sleep = 1'b0; #1;
        check(f_ce_n == 1'b1, "R8 deselect during sleep", 32'(f_ce_n), 32'd1);
        @(negedge clk); sel_wr = 1'b1; sel_on = 1'b0;
        @(posedge clk); @(negedge clk); sel_wr = 1'b0;
        check(f_ce_n == 1'b1, "R7 deselect", 32'(f_ce_n), 32'd1);

        // R9: ready/busy synchronizer
        @(negedge clk); rb_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check(dev_ready == 1'b1, "R9 one edge", 32'(dev_ready), 32'd1);
        @(posedge clk); @(negedge clk);
        check(dev_ready == 1'b0, "R9 two edges busy", 32'(dev_ready), 32'd0);
        rb_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(dev_ready == 1'b1, "R9 ready again", 32'(dev_ready), 32'd1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule